// File: doc/BRIEF.md
# Masked Vector Gather Sequencer

This block loads up to eight 64-bit elements from scattered memory locations into the lanes of a 512-bit destination register. A caller starts it with a base address, eight signed 32-bit indices, a 2-bit scale code, an eight-bit lane mask, the current destination contents, and the identifiers of the destination and index registers. Each lane's element address is the base plus the sign-extended index times the scale.

One invocation issues exactly one read of a 64-byte aligned line. The line is the one that holds the lowest active lane's element. Every active lane whose element lies in that same line is filled from the returned data, and its mask bit is cleared. The caller feeds the outgoing destination and mask back in, and re-triggers the block until the mask reads zero. If the mask is already empty, or the destination register identifier equals the index register identifier, the block finishes after one cycle without touching memory.

Top module: `gather_seq`

## Requirements
- R1: The element address of lane i is base_i + sext64(idx_i[32*i+:32]) * M modulo 2^64, where scale_i codes 0, 1, 2 and 3 select M = 1, 2, 4 and 8.
- R2: For an active invocation, mem_req_o rises one cycle after start_i is accepted. It stays high, with mem_addr_o unchanged, until the cycle in which mem_rvalid_i is high. mem_addr_o is the lowest active lane's element address with bits [5:0] cleared. Exactly one request is made per invocation.
- R3: The serviced lane set is the lowest set bit of mask_i plus every other mask_i lane whose address has the same bits [63:6]. It is therefore a subset of mask_i that always contains the lowest active lane.
- R4: A serviced lane i receives mem_rdata_i[64*k+:64], where k is bits [5:3] of lane i's address. Element addresses have bits [2:0] equal to zero.
- R5: On done_o, a lane that was not serviced returns its value from dst_i. mask_o equals mask_i with the serviced bits cleared, so repeated invocations empty any mask.
- R6: When dst_id_i equals idx_id_i at start, the block makes no memory request. done_o and err_o are high on the next cycle, mask_o equals mask_i and dst_o equals dst_i.
- R7: When mask_i is zero at start and the identifiers differ, the block makes no memory request. done_o is high on the next cycle with err_o low, mask_o zero and dst_o equal to dst_i.
- R8: done_o is a single-cycle pulse. For an active invocation, it is high on the cycle after the one in which mem_rvalid_i is accepted. start_i is ignored while an invocation is in progress.
- R9: After reset, done_o, err_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an invocation (accepted when idle) |
| base_i | input | 64 | Base byte address |
| idx_i | input | 256 | Eight signed 32-bit indices, lane i at [32*i+:32] |
| scale_i | input | 2 | Scale code: 0..3 selects 1, 2, 4, 8 |
| mask_i | input | 8 | Incoming lane mask |
| dst_id_i | input | 5 | Destination register identifier |
| idx_id_i | input | 5 | Index register identifier |
| dst_i | input | 512 | Current destination contents, lane i at [64*i+:64] |
| mem_rvalid_i | input | 1 | Line data valid for the pending request |
| mem_rdata_i | input | 512 | Returned 64-byte line, byte offset 8*k at [64*k+:64] |
| done_o | output | 1 | Invocation complete; results valid this cycle |
| err_o | output | 1 | Register-overlap error, valid with done_o |
| mask_o | output | 8 | Outgoing lane mask, valid with done_o |
| dst_o | output | 512 | Updated destination, valid with done_o |
| mem_req_o | output | 1 | Line read request, held until mem_rvalid_i |
| mem_addr_o | output | 64 | 64-byte aligned line address |

## Verification
The assertions assume two things about the inputs. Every lane that is active during a request must have an element address aligned to 8 bytes. mem_rvalid_i must arrive only while a request is pending. The stimulus satisfies the first by using 8-byte aligned base addresses and by choosing index values so that index times scale is always a multiple of 8. It satisfies the second by driving mem_rvalid_i only after mem_req_o has been seen high, with the latency varied from zero to three cycles. One invocation pulses start_i while a request is still outstanding, using a different mask, to show that the block ignores it.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DONE = 2'd2
  } gs_state_e;
endpackage

// File: rtl/gather_addr_gen.sv
module gather_addr_gen #(
  parameter int LANES   = 8,
  parameter int ADDR_W  = 64,
  parameter int IDX_W   = 32,
  parameter int SCALE_W = 2,
  parameter int OFF_W   = 6,
  parameter int ESZ_W   = 3,
  localparam int SEL_W  = OFF_W - ESZ_W,
  localparam int LADDR_W = ADDR_W - OFF_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          base_i,
  input  logic [LANES*IDX_W-1:0]     idx_i,
  input  logic [SCALE_W-1:0]         scale_i,
  input  logic [LANES-1:0]           chk_i,
  output logic [LANES*LADDR_W-1:0]   line_o,
  output logic [LANES*SEL_W-1:0]     off_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] ext;
    logic [ADDR_W-1:0] addr;
    assign ext  = {{(ADDR_W-IDX_W){idx_i[g*IDX_W+IDX_W-1]}}, idx_i[g*IDX_W +: IDX_W]};
    assign addr = base_i + (ext << scale_i);
    assign line_o[g*LADDR_W +: LADDR_W] = addr[ADDR_W-1:OFF_W];
    assign off_o[g*SEL_W +: SEL_W]      = addr[OFF_W-1:ESZ_W];

    assert_elem_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_i[g] |-> (addr[ESZ_W-1:0] == '0));
  end
endmodule

// File: rtl/gather_lane_pick.sv
module gather_lane_pick #(
  parameter int LANES   = 8,
  parameter int LADDR_W = 58,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LANES-1:0]         mask_i,
  input  logic [LANES*LADDR_W-1:0] line_i,
  output logic [LADDR_W-1:0]       lead_line_o,
  output logic [LANES-1:0]         svc_o
);
  logic [LIDX_W-1:0] lead;

  always_comb begin
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask_i[i]) lead = LIDX_W'(i);
    end
  end

  assign lead_line_o = line_i[lead*LADDR_W +: LADDR_W];

  for (genvar g = 0; g < LANES; g++) begin : g_hit
    assign svc_o[g] = mask_i[g] && (line_i[g*LADDR_W +: LADDR_W] == lead_line_o);
  end

  assert_svc_subset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_o & ~mask_i) == '0);
  assert_svc_lowest_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i != '0) |-> ((svc_o & (mask_i & (~mask_i + LANES'(1)))) != '0));
endmodule

// File: rtl/gather_lane_fill.sv
module gather_lane_fill #(
  parameter int LANES  = 8,
  parameter int ELEM_W = 64,
  parameter int LINE_W = 512,
  parameter int SEL_W  = 3
) (
  input  logic [LANES*ELEM_W-1:0] dst_i,
  input  logic [LINE_W-1:0]       line_i,
  input  logic [LANES*SEL_W-1:0]  off_i,
  input  logic [LANES-1:0]        svc_i,
  output logic [LANES*ELEM_W-1:0] dst_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SEL_W-1:0]  sel;
    logic [ELEM_W-1:0] word;
    assign sel  = off_i[g*SEL_W +: SEL_W];
    assign word = line_i[sel*ELEM_W +: ELEM_W];
    assign dst_o[g*ELEM_W +: ELEM_W] = svc_i[g] ? word : dst_i[g*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/gather_seq.sv
module gather_seq
  import gather_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int ELEM_W     = 64,
  parameter int ADDR_W     = 64,
  parameter int IDX_W      = 32,
  parameter int LINE_BYTES = 64,
  parameter int SCALE_W    = 2,
  parameter int RID_W      = 5,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int ESZ_W     = $clog2(ELEM_W / 8),
  localparam int SEL_W     = OFF_W - ESZ_W,
  localparam int LADDR_W   = ADDR_W - OFF_W,
  localparam int DST_W     = LANES * ELEM_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [ADDR_W-1:0]      base_i,
  input  logic [LANES*IDX_W-1:0] idx_i,
  input  logic [SCALE_W-1:0]     scale_i,
  input  logic [LANES-1:0]       mask_i,
  input  logic [RID_W-1:0]       dst_id_i,
  input  logic [RID_W-1:0]       idx_id_i,
  input  logic [DST_W-1:0]       dst_i,
  input  logic                   mem_rvalid_i,
  input  logic [LINE_W-1:0]      mem_rdata_i,
  output logic                   done_o,
  output logic                   err_o,
  output logic [LANES-1:0]       mask_o,
  output logic [DST_W-1:0]       dst_o,
  output logic                   mem_req_o,
  output logic [ADDR_W-1:0]      mem_addr_o
);
  gs_state_e state_q;
  logic [ADDR_W-1:0]      base_q;
  logic [LANES*IDX_W-1:0] idx_q;
  logic [SCALE_W-1:0]     scale_q;
  logic [LANES-1:0]       mask_cap_q, mask_q;
  logic [DST_W-1:0]       dst_q, dst_fill;
  logic                   err_q;

  logic [LANES*LADDR_W-1:0] lines;
  logic [LANES*SEL_W-1:0]   offs;
  logic [LADDR_W-1:0]       lead_line;
  logic [LANES-1:0]         svc, chk_en;

  logic accept, overlap, empty;
  assign accept  = start_i && (state_q == ST_IDLE);
  assign overlap = (dst_id_i == idx_id_i);
  assign empty   = (mask_i == '0);
  assign chk_en  = (state_q == ST_REQ) ? mask_cap_q : '0;

  gather_addr_gen #(
    .LANES(LANES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SCALE_W(SCALE_W),
    .OFF_W(OFF_W), .ESZ_W(ESZ_W)
  ) u_addr (
    .clk_i, .rst_ni, .base_i(base_q), .idx_i(idx_q), .scale_i(scale_q),
    .chk_i(chk_en), .line_o(lines), .off_o(offs)
  );

  gather_lane_pick #(.LANES(LANES), .LADDR_W(LADDR_W)) u_pick (
    .clk_i, .rst_ni, .mask_i(mask_cap_q), .line_i(lines),
    .lead_line_o(lead_line), .svc_o(svc)
  );

  gather_lane_fill #(
    .LANES(LANES), .ELEM_W(ELEM_W), .LINE_W(LINE_W), .SEL_W(SEL_W)
  ) u_fill (
    .dst_i(dst_q), .line_i(mem_rdata_i), .off_i(offs), .svc_i(svc), .dst_o(dst_fill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      base_q     <= '0;
      idx_q      <= '0;
      scale_q    <= '0;
      mask_cap_q <= '0;
      mask_q     <= '0;
      dst_q      <= '0;
      err_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          dst_q  <= dst_i;
          err_q  <= overlap;
          mask_q <= overlap ? mask_i : '0;
          if (overlap || empty) begin
            state_q <= ST_DONE;
          end else begin
            base_q     <= base_i;
            idx_q      <= idx_i;
            scale_q    <= scale_i;
            mask_cap_q <= mask_i;
            state_q    <= ST_REQ;
          end
        end
        ST_REQ: if (mem_rvalid_i) begin
          dst_q   <= dst_fill;
          mask_q  <= mask_cap_q & ~svc;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o     = (state_q == ST_DONE);
  assign err_o      = err_q;
  assign mask_o     = mask_q;
  assign dst_o      = dst_q;
  assign mem_req_o  = (state_q == ST_REQ);
  assign mem_addr_o = {lead_line, {OFF_W{1'b0}}};

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  assert_req_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=> !mem_req_o);
  assert_mask_shrink_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=>
      (($countones(mask_o) < $countones(mask_cap_q)) && ((mask_o & ~mask_cap_q) == '0)));
  assert_err_path_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && overlap) |=> (done_o && err_o && !mem_req_o));
  assert_empty_path_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !overlap && empty) |=> (done_o && !err_o && !mem_req_o && (mask_o == '0)));
  assert_done_after_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=> done_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/gather_seq_bench.sv
module gather_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0]  base = '0;
  logic [255:0] idx = '0;
  logic [1:0]   scale = '0;
  logic [7:0]   mask = '0;
  logic [4:0]   did = 5'd1, iid = 5'd2;
  logic [511:0] dst = '0;
  logic         rvalid = 1'b0;
  logic [511:0] rdata = '0;
  logic         done, err, mem_req;
  logic [7:0]   mask_out;
  logic [511:0] dst_out;
  logic [63:0]  mem_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [511:0] res_dst;
  logic [7:0]   res_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  gather_seq u_gather_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .idx_i(idx),
    .scale_i(scale), .mask_i(mask), .dst_id_i(did), .idx_id_i(iid), .dst_i(dst),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata), .done_o(done), .err_o(err),
    .mask_o(mask_out), .dst_o(dst_out), .mem_req_o(mem_req), .mem_addr_o(mem_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [511:0] act,
                     input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_word(input logic [63:0] line, input int k);
    return (line * 64'd3) ^ (64'h0123_4567_89AB_CDEF + 64'(k) * 64'h1111_0000_2222);
  endfunction

  function automatic logic [511:0] mem_line(input logic [63:0] line);
    logic [511:0] r;
    for (int k = 0; k < 8; k++) r[64*k +: 64] = mem_word(line, k);
    return r;
  endfunction

  // Behavioural model of one invocation, compared every clock.
  task automatic run(input logic [63:0] b, input logic [255:0] ix, input logic [1:0] sc,
                     input logic [7:0] m, input logic [4:0] d_id, input logic [4:0] i_id,
                     input logic [511:0] d, input int lat, input bit poke);
    longint unsigned a[8];
    logic [63:0] la;
    logic [7:0] svc, exp_mask;
    logic [511:0] exp_dst;
    int low;
    bit err_exp, active;
    for (int i = 0; i < 8; i++) begin
      longint si;
      si = longint'($signed(ix[32*i +: 32]));
      a[i] = b + longint'(si * (longint'(1) << sc));
    end
    err_exp = (d_id == i_id);
    active = !err_exp && (m != 0);
    exp_dst = d;
    exp_mask = err_exp ? m : 8'h00;
    svc = '0;
    la = '0;
    if (active) begin
      low = 0;
      while (!m[low]) low++;
      la = a[low] & ~64'h3F;
      for (int i = 0; i < 8; i++) begin
        if (m[i] && ((a[i] & ~64'h3F) == la)) begin
          svc[i] = 1'b1;
          exp_dst[64*i +: 64] = mem_word(la, int'(a[i][5:3]));
        end
      end
      exp_mask = m & ~svc;
    end
    base = b; idx = ix; scale = sc; mask = m; did = d_id; iid = i_id; dst = d;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    if (active) begin
      for (int c = 0; c <= lat; c++) begin
        chk(mem_req === 1'b1, "R2 req high while waiting", 512'(mem_req), 512'(1));
        chk(mem_addr === la, "R2 line address", 512'(mem_addr), 512'(la));
        chk(done === 1'b0, "R8 no done while waiting", 512'(done), 512'(0));
        if (poke && c == 0) begin
          start = 1'b1; mask = ~m;
        end else begin
          start = 1'b0; mask = m;
        end
        if (c == lat) begin
          rvalid = 1'b1;
          rdata = mem_line(la);
        end
        @(posedge clk); @(negedge clk);
        start = 1'b0;
      end
      rvalid = 1'b0;
      rdata = '0;
    end
    chk(done === 1'b1, "R8 done pulse", 512'(done), 512'(1));
    chk(mem_req === 1'b0, "R6/R7 no req at done", 512'(mem_req), 512'(0));
    chk(err === err_exp, "R6 err flag", 512'(err), 512'(err_exp));
    chk(mask_out === exp_mask, "R3/R5 mask_o", 512'(mask_out), 512'(exp_mask));
    chk(dst_out === exp_dst, "R1/R4/R5 dst_o", dst_out, exp_dst);
    res_dst = dst_out;
    res_mask = mask_out;
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0, "R8 done single cycle", 512'(done), 512'(0));
    chk(mem_req === 1'b0, "R2 single request", 512'(mem_req), 512'(0));
  endtask

  function automatic logic [255:0] idx_seq(input int start_v, input int step);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = 32'(start_v + i * step);
    return r;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [511:0] seed_dst;
    int n;
    for (int i = 0; i < 8; i++) seed_dst[64*i +: 64] = 64'hDEAD_0000_0000_0000 | 64'(i);
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && err === 1'b0 && mem_req === 1'b0, "R9 reset outputs",
        {done, err, mem_req}, 512'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4: all lanes in one line, scale code 3 (x8)
    run(64'h0000_0000_0010_0040, idx_seq(0, 1), 2'd3, 8'hFF, 5'd1, 5'd2, seed_dst, 0, 0);

    // R5: lanes one line apart; loop until mask empty, 8 invocations expected
    res_dst = seed_dst; res_mask = 8'hFF; n = 0;
    while (res_mask != 0 && n < 20) begin
      run(64'h0000_0000_0020_0000, idx_seq(0, 8), 2'd3, res_mask, 5'd3, 5'd4,
          res_dst, n % 4, 0);
      n++;
    end
    chk(n == 8, "R5 invocation count", 512'(n), 512'(8));

    // R1 R3: negative indices, scale x1, lowest active lane is 2
    run(64'h0000_0000_0030_0100, idx_seq(0, -8), 2'd0, 8'b1011_0100, 5'd5, 5'd6,
        seed_dst, 1, 0);
    // R1: scale x2 and x4, mixed lines
    run(64'h0000_0000_0040_0008, idx_seq(4, 12), 2'd1, 8'b0110_1011, 5'd7, 5'd8,
        seed_dst, 2, 0);
    run(64'hFFFF_FFFF_FFFF_FFC0, idx_seq(-6, 2), 2'd2, 8'hF0, 5'd9, 5'd10,
        seed_dst, 0, 0);
    // R6: register overlap
    run(64'h0000_0000_0050_0000, idx_seq(0, 1), 2'd3, 8'h5A, 5'd11, 5'd11, seed_dst, 0, 0);
    // R7: empty mask
    run(64'h0000_0000_0060_0000, idx_seq(0, 1), 2'd3, 8'h00, 5'd12, 5'd13, seed_dst, 0, 0);
    // R8: start pulsed while busy is ignored
    run(64'h0000_0000_0070_0000, idx_seq(0, 16), 2'd3, 8'b1000_0010, 5'd14, 5'd15,
        seed_dst, 3, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule